// File: doc/BRIEF.md
# Serial Transmitter Sequencer

This block is the transmit half of an asynchronous serial port. A processor writes bytes into a one-byte holding register. The block moves each byte into a shift register and sends it on a single line. The start of each bit is set by an external bit-rate tick, so the block itself has no baud divider. Besides data frames, the block also sends two special frame types. Raising the enable queues an all-ones idle frame, which acts as a preamble or as a delimiter between messages. The send-break control produces whole all-zeros frames.

The block keeps two status flags. One reports that the holding register is empty. The other reports that all shifting has finished. The completion flag is sticky: only a status read that observes it set, followed by a data write, clears it. A line-ownership output tells the surrounding pin logic when the transmitter drives the line. After the enable is dropped, the transmitter keeps ownership until the frames it has already committed are finished.

Top module: `serial_tx_seq`

## Requirements
- R1: After reset, `txd` is 1, `txd_oe` is 0, `tdre` is 1, `tc` is 1 and both interrupt outputs are 0.
- R2: Every bit lasts one tick period and changes only on a clock edge where `bit_tick` is high. A data frame is one 0 start bit, then the 8 data bits with bit 0 first, then one 1 stop bit. An idle frame is ten 1 bits and a break frame is ten 0 bits.
- R3: A rising edge of `tx_en` queues one idle frame. The idle frame goes out at the next frame boundary, after any frame already on the line, and buffered data waits behind it.
- R4: A write strobe loads the holding register and clears `tdre`. The byte enters the shifter at the next frame boundary where no break, mark or preamble takes precedence, and `tdre` then returns to 1.
- R5: While `brk_req` and `tx_en` are both high, break frames are sent back to back. A single-cycle pulse of `brk_req` still yields exactly one break frame. A frame already on the line when the break is requested finishes first. Breaking stops at the end of the break frame in progress once `brk_req` or `tx_en` is low.
- R6: After the last break frame, exactly one bit time of 1 (mark) is sent before the next frame.
- R7: `tc` sets at the tick that ends the last shifted bit when nothing further is queued. It never clears by itself.
- R8: `tc` clears only on a write strobe that follows a `stat_rd` strobe issued while `tc` was 1. A write without such a read leaves `tc` unchanged.
- R9: When `tx_en` is low, frames already committed (shifting, pending preamble, trailing mark) still complete with `txd_oe` high. Then `txd_oe` drops, the holding register is discarded (`tdre` = 1) and `txd` stays 1.
- R10: With `tx_en` high and nothing queued, `txd` is held at 1 and `txd_oe` stays high.
- R11: `irq_tdre` equals `tdre` AND `tdre_ie`. `irq_tc` equals `tc` AND `tc_ie`.
- R12: At a frame boundary the frame types are chosen in this priority order: break, then post-break mark, then preamble, then buffered data.
- R13: Dropping and raising `tx_en` while a frame shifts lets that frame finish. A preamble follows, and then the buffered byte if one is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Send break frames while high |
| tdre_ie | input | 1 | Enable for the buffer-empty interrupt |
| tc_ie | input | 1 | Enable for the completion interrupt |
| wr_stb | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte written with `wr_stb` |
| stat_rd | input | 1 | Status register read strobe |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Transmitter owns the line |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | All shifting complete (sticky) |
| irq_tdre | output | 1 | Buffer-empty interrupt |
| irq_tc | output | 1 | Completion interrupt |

## Verification
Each line bit appears on the clock edge that carries `bit_tick`. A new frame is chosen at the tick after the previous frame's last bit, so a byte written just after a tick with the line idle starts its start bit one tick later. `tdre` and `tc` change on the edge that follows the causing strobe. The interrupt outputs and `txd_oe` follow their inputs in the same cycle. The bench advances a queue-based model at every rising edge and compares all outputs at the falling edge, half a cycle after the registers settle. It also logs the line once per tick and decodes whole frames against these per-tick offsets.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [2:0] {
    FR_NONE,
    FR_MARK,
    FR_IDLE,
    FR_BREAK,
    FR_DATA
  } frame_kind_e;
endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              flush,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic full_n;

  always_comb begin
    full_n = full;
    if (take)   full_n = 1'b0;
    if (wr_stb) full_n = 1'b1;
    if (flush)  full_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
    end else begin
      full <= full_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
    end else if (wr_stb) begin
      data <= wr_data;
    end
  end
endmodule

// File: rtl/stx_shift.sv
module stx_shift #(
  parameter int FRAME_W = 10,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic [CNT_W-1:0]   load_cnt,
  output logic               busy,
  output logic               last,
  output logic               line
);
  logic [FRAME_W-1:0] sh, sh_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic               busy_n;
  logic               adv;

  assign last = busy && (cnt == CNT_W'(FRAME_W - 1));
  assign line = busy ? sh[0] : 1'b1;
  assign adv  = load || (tick && busy);

  always_comb begin
    sh_n   = sh;
    cnt_n  = cnt;
    busy_n = busy;
    if (load) begin
      sh_n   = load_word;
      cnt_n  = load_cnt;
      busy_n = 1'b1;
    end else if (tick && busy) begin
      if (last) begin
        busy_n = 1'b0;
      end else begin
        cnt_n = cnt + 1'b1;
        sh_n  = {1'b1, sh[FRAME_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (adv) begin
      sh   <= sh_n;
      cnt  <= cnt_n;
      busy <= busy_n;
    end
  end
endmodule

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 10,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               tx_en,
  input  logic               brk_req,
  input  logic               wr_stb,
  input  logic               stat_rd,
  input  logic               buf_full,
  input  logic [DATA_W-1:0]  buf_data,
  input  logic               busy,
  input  logic               last,
  output logic               load,
  output logic [FRAME_W-1:0] load_word,
  output logic [CNT_W-1:0]   load_cnt,
  output logic               take,
  output logic               flush,
  output logic               tc,
  output logic               oe
);
  frame_kind_e kind;
  logic bnd;
  logic en_q, brq_q, pre_pend, brk_pend, after_brk, rd_seen;
  logic pre_n, brkp_n, after_n, tc_n, rd_n;

  assign bnd = tick && (!busy || last);

  // frame choice at a boundary, highest priority first (R12)
  always_comb begin
    kind = FR_NONE;
    if (bnd) begin
      if (tx_en && (brk_pend || brk_req)) kind = FR_BREAK;
      else if (after_brk)                 kind = FR_MARK;
      else if (pre_pend)                  kind = FR_IDLE;
      else if (tx_en && buf_full)         kind = FR_DATA;
      else                                kind = FR_NONE;
    end
  end

  always_comb begin
    load_cnt = '0;
    case (kind)
      FR_BREAK: load_word = '0;
      FR_DATA:  load_word = {1'b1, buf_data, 1'b0};
      FR_MARK: begin
        load_word = '1;
        load_cnt  = CNT_W'(FRAME_W - 1);
      end
      default:  load_word = '1;
    endcase
  end

  assign load  = (kind != FR_NONE);
  assign take  = (kind == FR_DATA);
  assign flush = !tx_en && !busy && !pre_pend && !after_brk;
  assign oe    = tx_en || busy || pre_pend || after_brk;

  always_comb begin
    pre_n = pre_pend;
    if (kind == FR_IDLE)    pre_n = 1'b0;
    if (tx_en && !en_q)     pre_n = 1'b1;

    brkp_n = brk_pend;
    if (tx_en && brk_req && !brq_q && (kind != FR_BREAK)) brkp_n = 1'b1;
    else if ((kind == FR_BREAK) || !tx_en)               brkp_n = 1'b0;

    after_n = after_brk;
    if (kind == FR_BREAK) after_n = 1'b1;
    else if (load)        after_n = 1'b0;

    tc_n = tc;
    if (tick && last && (kind == FR_NONE)) tc_n = 1'b1;
    else if (wr_stb && rd_seen)            tc_n = 1'b0;

    rd_n = rd_seen;
    if (wr_stb)             rd_n = 1'b0;
    else if (stat_rd && tc) rd_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      brq_q     <= 1'b0;
      pre_pend  <= 1'b0;
      brk_pend  <= 1'b0;
      after_brk <= 1'b0;
      tc        <= 1'b1;
      rd_seen   <= 1'b0;
    end else begin
      en_q      <= tx_en;
      brq_q     <= brk_req;
      pre_pend  <= pre_n;
      brk_pend  <= brkp_n;
      after_brk <= after_n;
      tc        <= tc_n;
      rd_seen   <= rd_n;
    end
  end
endmodule

// File: rtl/serial_tx_seq.sv
module serial_tx_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              tdre_ie,
  input  logic              tc_ie,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic              txd,
  output logic              txd_oe,
  output logic              tdre,
  output logic              tc,
  output logic              irq_tdre,
  output logic              irq_tc
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic               buf_full, take, flush, load, busy, last;
  logic [DATA_W-1:0]  buf_data;
  logic [FRAME_W-1:0] load_word;
  logic [CNT_W-1:0]   load_cnt;

  stx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(take), .flush(flush), .full(buf_full), .data(buf_data)
  );

  stx_ctrl #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .tx_en(tx_en),
    .brk_req(brk_req), .wr_stb(wr_stb), .stat_rd(stat_rd),
    .buf_full(buf_full), .buf_data(buf_data), .busy(busy), .last(last),
    .load(load), .load_word(load_word), .load_cnt(load_cnt),
    .take(take), .flush(flush), .tc(tc), .oe(txd_oe)
  );

  stx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(load),
    .load_word(load_word), .load_cnt(load_cnt),
    .busy(busy), .last(last), .line(txd)
  );

  assign tdre     = !buf_full;
  assign irq_tdre = tdre && tdre_ie;
  assign irq_tc   = tc && tc_ie;
endmodule

// File: rtl/serial_tx_seq_chk.sv
module serial_tx_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_en,
  input logic wr_stb,
  input logic txd,
  input logic oe,
  input logic tdre,
  input logic tc
);
  assert_line_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  assert_empty_drop_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tdre && !wr_stb |=> tdre);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc && !wr_stb |=> tc);

  assert_done_clear_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tc) |-> $past(wr_stb));

  assert_owner_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && oe && !tick |=> oe);
endmodule

bind serial_tx_seq serial_tx_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(bit_tick), .tx_en(tx_en), .wr_stb(wr_stb),
  .txd(txd), .oe(txd_oe), .tdre(tdre), .tc(tc)
);

// File: tb/test_serial_tx_seq.sv
module test_serial_tx_seq;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, brk_req = 1'b0, tdre_ie = 1'b0, tc_ie = 1'b0;
  logic wr_stb = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic bit_tick;
  logic txd, txd_oe, tdre, tc, irq_tdre, irq_tc;

  int checks = 0;
  int fails = 0;
  int divc = 0;

  always #2.5ns clk = ~clk;

  always @(posedge clk) divc <= (divc == DIV - 1) ? 0 : divc + 1;
  assign bit_tick = (divc == 0);

  serial_tx_seq i_serial_tx_seq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .brk_req(brk_req), .tdre_ie(tdre_ie), .tc_ie(tc_ie), .wr_stb(wr_stb),
    .wr_data(wr_data), .stat_rd(stat_rd), .txd(txd), .txd_oe(txd_oe),
    .tdre(tdre), .tc(tc), .irq_tdre(irq_tdre), .irq_tc(irq_tc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: line bits held in a queue, one entry per bit time
  bit mq[$];
  bit m_pre, m_bpend, m_after, m_full, m_tc, m_rd, m_enq, m_bq;
  logic [7:0] m_buf;
  int sz, kd;
  bit bnd, ended, flush, o_full, o_tc, o_rd;
  logic [7:0] o_buf;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_pre = 0; m_bpend = 0; m_after = 0; m_full = 0;
      m_tc = 1; m_rd = 0; m_enq = 0; m_bq = 0; m_buf = 8'h00;
    end else begin
      sz = mq.size();
      bnd = bit_tick && (sz <= 1);
      ended = bit_tick && (sz == 1);
      kd = 0;
      if (bnd) begin
        if (tx_en && (m_bpend || brk_req)) kd = 1;
        else if (m_after)                  kd = 2;
        else if (m_pre)                    kd = 3;
        else if (tx_en && m_full)          kd = 4;
      end
      flush = !tx_en && (sz == 0) && !m_pre && !m_after;
      o_full = m_full; o_buf = m_buf; o_tc = m_tc; o_rd = m_rd;
      if (bit_tick && sz > 0) void'(mq.pop_front());
      case (kd)
        1: repeat (10) mq.push_back(1'b0);
        2: mq.push_back(1'b1);
        3: repeat (10) mq.push_back(1'b1);
        4: begin
          mq.push_back(1'b0);
          for (int i = 0; i < 8; i++) mq.push_back(o_buf[i]);
          mq.push_back(1'b1);
        end
        default: ;
      endcase
      if (tx_en && !m_enq) m_pre = 1;
      else if (kd == 3)    m_pre = 0;
      if (tx_en && brk_req && !m_bq && kd != 1) m_bpend = 1;
      else if (kd == 1 || !tx_en)               m_bpend = 0;
      if (kd == 1)      m_after = 1;
      else if (kd != 0) m_after = 0;
      m_full = o_full;
      if (kd == 4) m_full = 0;
      if (wr_stb) begin m_full = 1; m_buf = wr_data; end
      if (flush) m_full = 0;
      if (ended && kd == 0)     m_tc = 1;
      else if (wr_stb && o_rd)  m_tc = 0;
      if (wr_stb)               m_rd = 0;
      else if (stat_rd && o_tc) m_rd = 1;
      m_enq = tx_en;
      m_bq = brk_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 txd vs model", txd, (mq.size() > 0) ? mq[0] : 1'b1);
      chk("R9 txd_oe vs model", txd_oe, tx_en || mq.size() > 0 || m_pre || m_after);
      chk("R4 tdre vs model", tdre, !m_full);
      chk("R7 tc vs model", tc, m_tc);
      chk("R11 irq_tdre vs model", irq_tdre, !m_full && tdre_ie);
      chk("R11 irq_tc vs model", irq_tc, m_tc && tc_ie);
    end
  end

  // per-tick line log
  bit lg[$];
  logic tick_seen = 1'b0;
  always @(posedge clk) tick_seen <= bit_tick;
  always @(negedge clk) if (tick_seen) lg.push_back(txd);

  function automatic logic [7:0] dec(input int base);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = lg[base + i];
    return v;
  endfunction

  task automatic at_tick();
    @(posedge clk iff bit_tick);
    @(negedge clk);
    #1ns;
    lg.delete();
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff bit_tick);
    @(negedge clk);
    #1ns;
  endtask

  task automatic next_cyc();
    @(negedge clk);
    #1ns;
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_data = d;
    wr_stb = 1'b1;
    next_cyc();
    wr_stb = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1ns;
    rst_n = 1'b1;
    next_cyc();
    chk("R1 txd", txd, 1'b1);
    chk("R1 txd_oe", txd_oe, 1'b0);
    chk("R1 tdre", tdre, 1'b1);
    chk("R1 tc", tc, 1'b1);
    chk("R1 irqs", {irq_tdre, irq_tc}, 2'b00);

    // enable plus a write: preamble first, then the byte
    at_tick();
    tx_en = 1'b1;
    write_byte(8'hA5);
    wait_ticks(25);
    for (int i = 0; i < 10; i++) chk("R3 preamble bit", lg[i], 1'b1);
    chk("R3 start after preamble", lg[10], 1'b0);
    chk("R2 data lsb first", dec(11), 8'hA5);
    chk("R2 stop bit", lg[19], 1'b1);
    for (int i = 20; i < 25; i++) chk("R10 idle mark", lg[i], 1'b1);
    chk("R10 oe while idle", txd_oe, 1'b1);
    chk("R4 empty after transfer", tdre, 1'b1);
    chk("R8 write without read keeps tc", tc, 1'b1);

    // status read then write clears completion
    tdre_ie = 1'b1;
    tc_ie = 1'b1;
    next_cyc();
    chk("R11 irq_tdre raised", irq_tdre, 1'b1);
    at_tick();
    stat_rd = 1'b1;
    next_cyc();
    stat_rd = 1'b0;
    write_byte(8'h3C);
    chk("R8 tc cleared", tc, 1'b0);
    chk("R11 irq_tc low", irq_tc, 1'b0);
    wait_ticks(14);
    chk("R7 tc set at end", tc, 1'b1);
    chk("R11 irq_tc high", irq_tc, 1'b1);

    // break pulse during a data frame
    at_tick();
    write_byte(8'h81);
    wait_ticks(3);
    brk_req = 1'b1;
    next_cyc();
    brk_req = 1'b0;
    wait_ticks(20);
    chk("R5 frame finishes first", dec(1), 8'h81);
    chk("R5 frame stop", lg[9], 1'b1);
    for (int i = 10; i < 20; i++) chk("R5 single break frame", lg[i], 1'b0);
    chk("R6 mark after break", lg[20], 1'b1);
    chk("R6 idle after mark", lg[21], 1'b1);

    // held break with a buffered byte
    at_tick();
    brk_req = 1'b1;
    write_byte(8'h5A);
    wait_ticks(24);
    brk_req = 1'b0;
    wait_ticks(20);
    for (int i = 0; i < 30; i++) chk("R5 held break", lg[i], 1'b0);
    chk("R6 one mark bit", lg[30], 1'b1);
    chk("R12 data right after mark", lg[31], 1'b0);
    chk("R12 buffered byte", dec(32), 8'h5A);

    // drop and raise enable mid-frame
    at_tick();
    write_byte(8'hC3);
    wait_ticks(2);
    write_byte(8'h96);
    tx_en = 1'b0;
    next_cyc();
    tx_en = 1'b1;
    wait_ticks(32);
    chk("R13 running frame", dec(1), 8'hC3);
    for (int i = 10; i < 20; i++) chk("R13 delimiter preamble", lg[i], 1'b1);
    chk("R13 buffered start", lg[20], 1'b0);
    chk("R13 buffered byte", dec(21), 8'h96);

    // disable with a byte buffered
    at_tick();
    write_byte(8'h11);
    wait_ticks(2);
    write_byte(8'h22);
    tx_en = 1'b0;
    wait_ticks(14);
    chk("R9 committed frame sent", dec(1), 8'h11);
    for (int i = 10; i < lg.size(); i++) chk("R9 buffer not sent", lg[i], 1'b1);
    chk("R9 line released", txd_oe, 1'b0);
    chk("R9 buffer discarded", tdre, 1'b1);
    chk("R9 line high", txd, 1'b1);
    chk("R7 tc after disable", tc, 1'b1);

    summary();
    $finish;
  end
endmodule